// File: doc/BRIEF.md
# Weighted single-fault injection selector

This block chooses which one of N faultable elements in a circuit under test receives a fault on each injection event. One shared 16-bit pseudo-random source produces a value. A range decoder compares that value with a table of cumulative thresholds. Each element owns a slice of the 16-bit value range, and the size of that slice is proportional to the element's relative fault probability. Exactly one element is picked per event, so the block never produces concurrent faults on several elements.

A test controller loads a seed, writes the threshold table through a small index/data/write-enable port while no injection is in flight, and then pulses a request. One cycle after the request is accepted, the block presents a one-hot fault-enable vector and the binary index of the chosen element, together with a single-cycle valid strobe. The vector is all zeros at every other time.

Top module: `wfault_pick`

## Requirements
- R1: After reset, `fault_vec` is all zeros, `fault_vld` is 0 and `fault_idx` is 0.
- R2: The random state is a 16-bit Galois LFSR. One step is `next = {1'b0, s[15:1]} ^ (s[0] ? 16'hB400 : 16'h0000)`, which corresponds to taps 16, 14, 13 and 11. Reset loads 16'hACE1. While `seed_ld` is high, the state is loaded from `seed_val` on the clock edge, and a value of zero is replaced by 16'h0001. The state steps once per accepted request.
- R3: Given the stepped value r, element k is selected when thr[k-1] < r <= thr[k], where thr[-1] is taken as -1. Element 0 therefore covers 0 up to and including thr[0].
- R4: An element whose threshold equals that of the element below it has zero weight and is never selected.
- R5: A request is accepted on edge E. The result (`fault_vec`, `fault_idx`, `fault_vld`=1) is then visible after edge E+1, and `fault_vld` falls after edge E+2.
- R6: A request is ignored while a result is pending, while `fault_vld` is high, or in a cycle where `seed_ld` is high. An ignored request neither steps the state nor produces a result.
- R7: When `fault_vld` is 0, `fault_vec` is all zeros. When `fault_vld` is 1, exactly one bit is set, and that bit is bit `fault_idx`.
- R8: A write with `tbl_we` high stores `tbl_data` into thr[`tbl_idx`]. Reset fills the table uniformly: thr[k] = ((k+1)·65536)/N − 1, so the last entry is 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_ld | input | 1 | Load the random state from seed_val |
| seed_val | input | 16 | Seed value (zero maps to 1) |
| inj_req | input | 1 | Injection request |
| tbl_we | input | 1 | Threshold table write enable |
| tbl_idx | input | IW = clog2(N) | Threshold entry to write |
| tbl_data | input | 16 | Cumulative threshold value |
| fault_vec | output | N | One-hot fault enable, zero when idle |
| fault_idx | output | IW | Index of the selected element |
| fault_vld | output | 1 | One-cycle result strobe |

## Verification
The hardest cases to reach from the ports are the exact range boundaries: a random value equal to a threshold, or just above a threshold that is shared with a zero-weight neighbour. Random draws land there only rarely. The bench reaches these values on purpose by inverting one LFSR step. It computes the predecessor of each target value, loads that predecessor as the seed, and then requests one injection so that the stepped value hits the boundary exactly. Requests held high through the pending and valid cycles, and requests that coincide with a seed load, check that the state advances only once per accepted event.

// File: rtl/wfault_pick.sv
module wfault_pick #(
  parameter int N = 8,
  parameter logic [15:0] RST_SEED = 16'hACE1,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seed_ld,
  input  logic [15:0]   seed_val,
  input  logic          inj_req,
  input  logic          tbl_we,
  input  logic [IW-1:0] tbl_idx,
  input  logic [15:0]   tbl_data,
  output logic [N-1:0]  fault_vec,
  output logic [IW-1:0] fault_idx,
  output logic          fault_vld
);
  localparam logic [15:0] TAPS = 16'hB400;

  logic [N-1:0][15:0] thr;
  logic [15:0]        lfsr;
  logic               pend;
  logic [N-1:0]       hit;
  logic [IW-1:0]      hit_idx;

  wire        accept   = inj_req && !seed_ld && !pend && !fault_vld;
  wire [15:0] lfsr_nxt = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? TAPS : 16'h0000);

  for (genvar k = 0; k < N; k++) begin : g_ent
    localparam logic [15:0] INIT = 16'((((k + 1) * 65536) / N) - 1);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) thr[k] <= INIT;
      else if (tbl_we && tbl_idx == IW'(k)) thr[k] <= tbl_data;

    if (k == 0) begin : g_lo
      assign hit[k] = lfsr <= thr[k];
    end else begin : g_hi
      assign hit[k] = (lfsr <= thr[k]) && (lfsr > thr[k-1]);
    end
  end

  always_comb begin
    hit_idx = '0;
    for (int k = N - 1; k >= 0; k--)
      if (hit[k]) hit_idx = IW'(k);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr      <= RST_SEED;
      pend      <= 1'b0;
      fault_vec <= '0;
      fault_idx <= '0;
      fault_vld <= 1'b0;
    end else begin
      if (seed_ld)     lfsr <= (seed_val == 16'h0) ? 16'h0001 : seed_val;
      else if (accept) lfsr <= lfsr_nxt;
      pend      <= accept;
      fault_vld <= pend;
      fault_vec <= pend ? hit : '0;
      if (pend) fault_idx <= hit_idx;
    end
  end
endmodule

// File: rtl/wfault_pick_chk.sv
module wfault_pick_chk #(
  parameter int N = 8,
  parameter int IW = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               seed_ld,
  input logic [15:0]        seed_val,
  input logic [N-1:0]       fault_vec,
  input logic [IW-1:0]      fault_idx,
  input logic               fault_vld,
  input logic [15:0]        lfsr,
  input logic [N-1:0][15:0] thr
);
  p_vec_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_vld |-> fault_vec == '0);

  p_one_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_vld |-> $countones(fault_vec) == 1);

  p_idx_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_vld |-> fault_vec[fault_idx]);

  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_vld |=> !fault_vld);

  p_zero_weight_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_vld && fault_idx != '0) |-> thr[fault_idx] != thr[IW'(fault_idx - 1'b1)]);

  p_state_nz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 16'h0);

  p_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seed_ld |=> lfsr == (($past(seed_val) == 16'h0) ? 16'h0001 : $past(seed_val)));
endmodule

bind wfault_pick wfault_pick_chk #(.N(N), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .seed_ld(seed_ld), .seed_val(seed_val),
  .fault_vec(fault_vec), .fault_idx(fault_idx), .fault_vld(fault_vld),
  .lfsr(lfsr), .thr(thr)
);

// File: tb/sim_wfault_pick.sv
`timescale 1ns/1ps
module sim_wfault_pick;
  localparam int N = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic seed_ld = 0, inj_req = 0, tbl_we = 0;
  logic [15:0] seed_val = 0, tbl_data = 0;
  logic [IW-1:0] tbl_idx = 0;
  logic [N-1:0] fault_vec;
  logic [IW-1:0] fault_idx;
  logic fault_vld;

  int checks = 0, failures = 0;
  logic [15:0] m_lfsr;
  int m_thr [N];

  always #2.5 clk = ~clk;

  wfault_pick #(.N(N)) u0 (.*);

  function automatic logic [15:0] step(logic [15:0] s);
    return {1'b0, s[15:1]} ^ (s[0] ? 16'hB400 : 16'h0000);
  endfunction

  function automatic logic [15:0] unstep(logic [15:0] t);
    return t[15] ? (((t ^ 16'hB400) << 1) | 16'h0001) : (t << 1);
  endfunction

  function automatic int decode(logic [15:0] r);
    for (int k = 0; k < N; k++)
      if (int'(r) <= m_thr[k]) return k;
    return N;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic wr_thr(int k, int v);
    @(negedge clk);
    tbl_we = 1; tbl_idx = IW'(k); tbl_data = 16'(v);
    @(negedge clk);
    tbl_we = 0;
    m_thr[k] = v;
  endtask

  task automatic load_seed(logic [15:0] s);
    @(negedge clk);
    seed_ld = 1; seed_val = s;
    @(negedge clk);
    seed_ld = 0;
    m_lfsr = (s == 16'h0) ? 16'h0001 : s;
  endtask

  task automatic inject(bit hold, string tag);
    int e;
    @(negedge clk);
    inj_req = 1;
    @(negedge clk);
    inj_req = hold;
    m_lfsr = step(m_lfsr);
    e = decode(m_lfsr);
    check(!fault_vld && fault_vec == '0, "R5 pending cycle quiet", fault_vld, 0);
    @(negedge clk);
    check(fault_vld == 1, {tag, " R5 valid"}, fault_vld, 1);
    check(fault_vec == (N'(1) << e), {tag, " R3 vector"}, fault_vec, longint'(1) << e);
    check(int'(fault_idx) == e, {tag, " R3 index"}, fault_idx, e);
    if (e > 0)
      check(m_thr[e] != m_thr[e-1], "R4 zero-weight element chosen", e, e);
    @(negedge clk);
    inj_req = 0;
    check(!fault_vld && fault_vec == '0, "R7 vector cleared / R6 no second result", fault_vec, 0);
  endtask

  task automatic at_value(logic [15:0] target, int exp_k, string tag);
    load_seed(unstep(target));
    inject(0, tag);
    check(decode(target) == exp_k, {tag, " R3 boundary model"}, decode(target), exp_k);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int w [N];
    longint tot, cum;
    m_lfsr = 16'hACE1;
    for (int k = 0; k < N; k++) m_thr[k] = ((k + 1) * 65536) / N - 1;
    repeat (3) @(negedge clk);
    check(fault_vld == 0, "R1 valid after reset", fault_vld, 0);
    check(fault_vec == '0, "R1 vector after reset", fault_vec, 0);
    check(fault_idx == '0, "R1 index after reset", fault_idx, 0);
    rst_n = 1;
    @(negedge clk);
    check(fault_vld == 0 && fault_vec == '0, "R1 idle after release", fault_vec, 0);

    inject(0, "R8 reset table R2 reset seed");
    inject(1, "R6 held request");
    inject(0, "R6 single step after hold");

    load_seed(16'h0000);
    inject(0, "R2 zero seed");

    @(negedge clk);
    seed_ld = 1; seed_val = 16'h5A5A; inj_req = 1;
    @(negedge clk);
    seed_ld = 0; inj_req = 0;
    m_lfsr = 16'h5A5A;
    repeat (2) @(negedge clk);
    check(fault_vld == 0 && fault_vec == '0, "R6 request during seed load", fault_vld, 0);
    inject(0, "R2 after seed load");

    wr_thr(0, 16'h0FFF); wr_thr(1, 16'h1FFF); wr_thr(2, 16'h3FFF); wr_thr(3, 16'h3FFF);
    wr_thr(4, 16'h7FFF); wr_thr(5, 16'h9FFF); wr_thr(6, 16'hBFFF); wr_thr(7, 16'hFFFF);
    at_value(16'h0FFF, 0, "R3 upper edge of 0");
    at_value(16'h1000, 1, "R3 lower edge of 1");
    at_value(16'h3FFF, 2, "R3 upper edge of 2");
    at_value(16'h4000, 4, "R4 skip zero weight 3");
    at_value(16'hBFFF, 6, "R3 upper edge of 6");
    at_value(16'hC000, 7, "R3 lower edge of 7");
    at_value(16'hFFFF, 7, "R3 top of range");

    void'($urandom(32'd1234));
    for (int t = 0; t < 6; t++) begin
      tot = 0;
      for (int k = 0; k < N; k++) begin
        w[k] = (k != 0 && ($urandom % 4) == 0) ? 0 : int'($urandom % 1000) + 1;
        tot += w[k];
      end
      cum = 0;
      for (int k = 0; k < N; k++) begin
        cum += w[k];
        wr_thr(k, int'((cum * 65536) / tot - 1));
      end
      load_seed(16'($urandom));
      for (int i = 0; i < 40; i++) inject(bit'($urandom % 2), "R3 random draw");
    end

    summary();
  end
endmodule